// File: doc/BRIEF.md
# External Overlay Palette Mixer

This block places pixels from an external on-screen-display source over a decoded video stream. The overlay source sends a 4-bit color index. The block samples that index on every second edge of the system clock, which gives a 13.5 MHz pixel rate from a 27 MHz clock. The index passes through a two-stage sample pipeline and selects one of sixteen 16-bit colors in a lookup table. A video pixel that arrives at the same moment is delayed by the same amount, so the overlay color and the video pixel it covers reach the mixer together.

A host loads the table through one 8-bit write port that steps through the table by itself. The host first pulses a clear command to return the write pointer to entry 0. It then writes bytes in pairs: the upper byte (luma) of an entry first, then the lower byte (chroma). Thirty-two writes fill the whole table. An entry whose luma and chroma are both zero is a transparency key: wherever the overlay uses that color, the video pixel shows through. Any other entry replaces the video pixel in full. Mixing is always active. If the eight entries whose index bit 3 is clear are all transparent, that bit works as an overlay blank control.

Top module: `ext_overlay_mixer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mix_luma`, `mix_chroma` and `mix_valid` are zero. Reset also clears every table entry to 0x0000, which makes every entry transparent.
- R2: A `host_clr` pulse sets the write pointer to entry 0 and the next byte to "upper". This happens even when a half-written pair is pending. If `host_wr` is high in the same cycle as `host_clr`, that write is discarded.
- R3: Host writes alternate. The first byte of a pair goes to bits [15:8] of the current entry (luma). The second byte goes to bits [7:0] (chroma) and then moves the pointer to the next entry. After a clear, 32 writes load entries 0 through 15 in order.
- R4: The write pointer wraps to entry 0 after the low byte of entry 15, so the 33rd and 34th writes overwrite entry 0.
- R5: Index and video are sampled only on alternate clock edges. The first sample is taken on the second rising edge after reset is released. A value held only between two sampling edges is never used.
- R6: An index and video pair sampled on edge n appears on the outputs after edge n+4. `mix_valid` is high for exactly the one cycle that follows each output update, and the outputs do not change at any other time.
- R7: When the selected entry is 0x0000, the output is the video pixel that was sampled with that index: luma and chroma both.
- R8: When the selected entry is not 0x0000, the output luma is the entry's bits [15:8] and the output chroma is its bits [7:0]. The video is ignored.
- R9: An entry with only one field zero, such as 0x00A0 or 0x7700, is not transparent and is output unchanged.
- R10: With entries 0 through 7 transparent, every index that has bit 3 clear passes the video through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (27 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| host_clr | input | 1 | Resets the table write pointer and byte phase |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host write byte |
| ovl_idx | input | 4 | External overlay color index |
| vid_luma | input | 8 | Incoming video luma |
| vid_chroma | input | 8 | Incoming video chroma |
| mix_luma | output | 8 | Mixed output luma |
| mix_chroma | output | 8 | Mixed output chroma |
| mix_valid | output | 1 | High the cycle after each output update |

## Verification
The bench checks the byte pairing after a pending half pair is abandoned by a clear. It also checks a clear that arrives together with a write. A design that lets either byte through would build entry 0 from the wrong byte, for example 0x9933 instead of 0x3344. It writes 34 bytes to make the pointer wrap. A pointer that saturated or stepped after each byte would leave entry 0 unchanged or put the bytes in the wrong entries. It changes the index every cycle, so a design that sampled on the wrong phase, or on every edge, would show the color that should have been dropped. It also times one index change down to the cycle and uses entries with a single zero field, which catches a pipeline of the wrong depth and a transparency test that checks only one field.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int FIELD_W = 8;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t luma;
        field_t chroma;
    } pix_t;

    localparam int PIX_W = $bits(pix_t);

    typedef enum logic {
        BYTE_UPPER = 1'b0,
        BYTE_LOWER = 1'b1
    } byte_sel_e;

    function automatic logic is_key(input pix_t p);
        return (p.luma == '0) && (p.chroma == '0);
    endfunction

endpackage

// File: rtl/ovl_palette.sv
module ovl_palette
    import ovl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  field_t           wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output pix_t             rd_entry
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0] ptr_q;
    byte_sel_e        sel_q;
    pix_t             table_q [ENTRIES];

    logic accept;
    assign accept = wr && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr_q <= '0;
            sel_q <= BYTE_UPPER;
        end else if (wr) begin
            if (sel_q == BYTE_UPPER) begin
                sel_q <= BYTE_LOWER;
            end else begin
                sel_q <= BYTE_UPPER;
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = accept && (ptr_q == IDX_W'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[e] <= '0;
            end else if (hit && sel_q == BYTE_UPPER) begin
                table_q[e].luma <= wdata;
            end else if (hit && sel_q == BYTE_LOWER) begin
                table_q[e].chroma <= wdata;
            end
        end
    end

    assign rd_entry = table_q[rd_idx];

    p_clear_home_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr_q == '0) && (sel_q == BYTE_UPPER));

    p_byte_alternates_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (sel_q != $past(sel_q)));

    p_ptr_steps_on_lower_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && sel_q == BYTE_LOWER) |=> (ptr_q == $past(ptr_q) + 1'b1));

    p_ptr_wraps_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && sel_q == BYTE_LOWER && ptr_q == IDX_W'(ENTRIES - 1)) |=> (ptr_q == '0));

    p_ptr_still_on_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(wr && sel_q == BYTE_LOWER)) |=> $stable(ptr_q));

endmodule

// File: rtl/ovl_sampler.sv
module ovl_sampler #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else if (en) begin
                if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    p_last_stage_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

endmodule

// File: rtl/ovl_mixer.sv
module ovl_mixer
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  pix_t video,
    input  pix_t entry,
    output pix_t mix,
    output logic mix_valid
);
    pix_t mix_q;
    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= en;
            if (en) begin
                mix_q <= is_key(entry) ? video : entry;
            end
        end
    end

    assign mix       = mix_q;
    assign mix_valid = valid_q;

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    p_quiet_between_r6: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(mix_q));

endmodule

// File: rtl/ext_overlay_mixer.sv
module ext_overlay_mixer
    import ovl_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_clr,
    input  logic             host_wr,
    input  logic [7:0]       host_wdata,
    input  logic [IDX_W-1:0] ovl_idx,
    input  logic [7:0]       vid_luma,
    input  logic [7:0]       vid_chroma,
    output logic [7:0]       mix_luma,
    output logic [7:0]       mix_chroma,
    output logic             mix_valid
);
    logic             tick_q;
    logic [IDX_W-1:0] idx_s;
    logic [PIX_W-1:0] vid_s;
    pix_t             vid_in;
    pix_t             entry;
    pix_t             mix;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= !tick_q;
        end
    end

    assign vid_in = '{luma: vid_luma, chroma: vid_chroma};

    ovl_sampler #(.W(IDX_W), .STAGES(SYNC_STAGES)) u_idx_sync (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_q),
        .din  (ovl_idx),
        .dout (idx_s)
    );

    ovl_sampler #(.W(PIX_W), .STAGES(SYNC_STAGES)) u_vid_align (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_q),
        .din  (vid_in),
        .dout (vid_s)
    );

    ovl_palette #(.IDX_W(IDX_W)) u_palette (
        .clk      (clk),
        .rst      (rst),
        .clr      (host_clr),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .rd_idx   (idx_s),
        .rd_entry (entry)
    );

    ovl_mixer u_mixer (
        .clk       (clk),
        .rst       (rst),
        .en        (tick_q),
        .video     (pix_t'(vid_s)),
        .entry     (entry),
        .mix       (mix),
        .mix_valid (mix_valid)
    );

    assign mix_luma   = mix.luma;
    assign mix_chroma = mix.chroma;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (mix_luma == '0 && mix_chroma == '0 && !mix_valid));

    p_tick_alternates_r5: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

endmodule

// File: tb/tb_ext_overlay_mixer.sv
module tb_ext_overlay_mixer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_clr = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [3:0] ovl_idx = '0;
    logic [7:0] vid_luma = '0;
    logic [7:0] vid_chroma = '0;
    logic [7:0] mix_luma;
    logic [7:0] mix_chroma;
    logic       mix_valid;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string sect = "R1";

    int m_tab [16];
    int m_ptr, m_sel, m_tick, m_out, m_valid;
    int m_iq [$];
    int m_vq [$];

    always #2.5 clk = !clk;

    ext_overlay_mixer dut (
        .clk(clk), .rst(rst), .host_clr(host_clr), .host_wr(host_wr),
        .host_wdata(host_wdata), .ovl_idx(ovl_idx), .vid_luma(vid_luma),
        .vid_chroma(vid_chroma), .mix_luma(mix_luma), .mix_chroma(mix_chroma),
        .mix_valid(mix_valid)
    );

    // Behavioural reference, advanced once per rising edge from the driven inputs.
    always @(posedge clk) begin
        int ent;
        if (rst) begin
            foreach (m_tab[i]) m_tab[i] = 0;
            m_ptr = 0; m_sel = 0; m_tick = 0; m_out = 0; m_valid = 0;
            m_iq = '{0, 0};
            m_vq = '{0, 0};
        end else begin
            if (m_tick != 0) begin
                ent = m_tab[m_iq[0]];
                m_out = (ent == 0) ? m_vq[0] : ent;
                void'(m_iq.pop_front());
                void'(m_vq.pop_front());
                m_iq.push_back(int'(ovl_idx));
                m_vq.push_back(int'({vid_luma, vid_chroma}));
            end
            m_valid = m_tick;
            m_tick = (m_tick == 0) ? 1 : 0;
            if (host_clr) begin
                m_ptr = 0; m_sel = 0;
            end else if (host_wr) begin
                if (m_sel == 0) begin
                    m_tab[m_ptr] = (m_tab[m_ptr] & 'hFF) | (int'(host_wdata) << 8);
                    m_sel = 1;
                end else begin
                    m_tab[m_ptr] = (m_tab[m_ptr] & 'hFF00) | int'(host_wdata);
                    m_sel = 0;
                    m_ptr = (m_ptr + 1) % 16;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if ({mix_luma, mix_chroma} !== 16'(m_out) || mix_valid !== (m_valid != 0)) begin
                n_bad++;
                $display("FAIL %s: out=%h valid=%b expected out=%h valid=%0d",
                         sect, {mix_luma, mix_chroma}, mix_valid, 16'(m_out), m_valid);
            end
        end
    end

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wbyte(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic clear();
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
    endtask

    function automatic logic [15:0] pal(input int e);
        if (e < 8)   return 16'h0000;
        if (e == 9)  return 16'h00A0;
        if (e == 10) return 16'h7700;
        return {8'(8'h40 + e), 8'(8'hC0 + e)};
    endfunction

    task automatic load_all();
        clear();
        for (int e = 0; e < 16; e++) begin
            wbyte(pal(e)[15:8]);
            wbyte(pal(e)[7:0]);
        end
    endtask

    task automatic hold(input int idx, input logic [15:0] vid, input string tag,
                        input logic [15:0] exp);
        ovl_idx = 4'(idx); {vid_luma, vid_chroma} = vid;
        repeat (10) @(negedge clk);
        check(tag, {1'b0, mix_luma, mix_chroma}, {1'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {mix_valid, mix_luma, mix_chroma}, 17'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {mix_valid, mix_luma, mix_chroma}, 17'h0);
        sect = "R1";
        hold(11, 16'hBEEF, "R1", 16'hBEEF);

        sect = "R3";
        load_all();
        sect = "R8";
        hold(8, 16'h1234, "R8", 16'h48C8);
        hold(15, 16'h1234, "R8", 16'h4FCF);
        sect = "R7";
        hold(2, 16'h5566, "R7", 16'h5566);
        sect = "R9";
        hold(9, 16'h1234, "R9", 16'h00A0);
        hold(10, 16'h1234, "R9", 16'h7700);

        sect = "R2";
        clear();
        wbyte(8'hAA);
        clear();
        host_clr = 1'b1; host_wr = 1'b1; host_wdata = 8'h99;
        @(negedge clk);
        host_clr = 1'b0; host_wr = 1'b0;
        wbyte(8'h33);
        wbyte(8'h44);
        hold(0, 16'h1111, "R2", 16'h3344);

        sect = "R4";
        load_all();
        wbyte(8'h5A);
        wbyte(8'hA5);
        hold(0, 16'h2222, "R4", 16'h5AA5);
        hold(1, 16'h2323, "R4", 16'h2323);
        clear();
        wbyte(8'h00);
        wbyte(8'h00);

        sect = "R6";
        ovl_idx = 4'd8; {vid_luma, vid_chroma} = 16'h0F0F;
        repeat (8) @(negedge clk);
        while (mix_valid !== 1'b1) @(negedge clk);
        ovl_idx = 4'd12;
        repeat (5) @(negedge clk);
        check("R6", {mix_valid, mix_luma, mix_chroma}, {1'b0, 16'h48C8});
        @(negedge clk);
        check("R6", {mix_valid, mix_luma, mix_chroma}, {1'b1, 16'h4CCC});

        sect = "R5";
        while (mix_valid !== 1'b1) @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            ovl_idx = 4'd15;
            @(negedge clk);
            ovl_idx = 4'd8;
            @(negedge clk);
        end
        check("R5", {1'b0, mix_luma, mix_chroma}, {1'b0, 16'h48C8});
        for (int k = 0; k < 40; k++) begin
            ovl_idx = 4'(k * 7);
            {vid_luma, vid_chroma} = 16'(k * 16'h0913);
            @(negedge clk);
        end

        sect = "R10";
        for (int k = 0; k < 64; k++) begin
            ovl_idx = 4'(k % 8);
            {vid_luma, vid_chroma} = 16'(16'h1357 + k * 16'h0421);
            @(negedge clk);
        end
        hold(5, 16'h6A6A, "R10", 16'h6A6A);
        hold(13, 16'h6A6A, "R10", 16'h4DCD);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule